// File: doc/BRIEF.md
# Load-Store Ordering Violation Detector

This block watches the memory operations of an out-of-order core and catches loads that read memory before an older store to the same location had resolved its address. Loads and stores are entered into two age-ordered circular queues when they are allocated in program order. They may then execute in any order, and they leave from the queue head when they retire. Each store that executes compares its address against every younger load that has already executed. If any match, the oldest matching load is reported on a one-cycle squash pulse, together with its slot and instruction address, so that the front end can refetch from that load. The queues drop that load and every younger entry in the same edge.

The instruction address of each violating load trains a small table of wait marks. A load allocated later whose address selects a set mark captures it. While any older store in the store queue has not executed, such a load is reported as one that must hold back. All marks are wiped on a fixed period, so a load that stopped conflicting regains full freedom. Cache access and store-to-load data forwarding are outside this block.

Top module: `ld_st_order_check`

## Requirements
- R1: After reset both queues are empty, `lq_full`, `sq_full`, `squash_valid` and `hold_wait` are low, and `alloc_slot` is 0.
- R2: Each queue holds QDEPTH entries (default 32). Its full flag is high at QDEPTH entries, and an allocation of that kind is ignored while full.
- R3: When a store executes and a younger load has already executed to the same 8-byte block, `squash_valid` is high for the one cycle after the store's execute cycle, with that load's slot on `squash_slot` and its instruction address on `squash_pc`.
- R4: Loads older than the executing store, and younger loads that have not yet executed, never cause a squash.
- R5: Two addresses match exactly when they agree in every bit above bit 2. Bits 2:0 are ignored.
- R6: When several younger executed loads match, the squash reports the oldest of them.
- R7: A squash frees the reported load and every younger load and store. The next load allocation returns the reported load's slot, and the next store allocation returns the slot of the oldest freed store.
- R8: A load executing in the same cycle as a matching older store counts as already executed and is squashed.
- R9: A squash sets the wait mark selected by bits [7:2] of the load's instruction address (default 64 marks). A load allocated later with an address selecting a set mark has `hold_wait` high for its slot while any store older than it has not executed, and low once all of them have executed.
- R10: A load whose address selects a clear mark, or a load with no older store in the queue, never has `hold_wait` high.
- R11: All wait marks are cleared every CLEAR_PERIOD cycles (default 16384). A squash in the clearing cycle still sets its mark.
- R12: Retirement frees queue entries from the head in order, and slot numbers wrap around the queue.
- R13: An allocation presented in the same cycle as a squashing store execute is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate one memory operation in program order |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_pc | input | PC_W | Instruction address of the allocated operation |
| alloc_slot | output | IDX_W | Queue slot the allocation receives (load or store queue, by `alloc_is_store`) |
| lq_full | output | 1 | Load queue holds QDEPTH entries |
| sq_full | output | 1 | Store queue holds QDEPTH entries |
| ld_exec_valid | input | 1 | A load executes |
| ld_exec_slot | input | IDX_W | Slot of the executing load |
| ld_exec_addr | input | ADDR_W | Address of the executing load |
| st_exec_valid | input | 1 | A store resolves its address |
| st_exec_slot | input | IDX_W | Slot of the executing store |
| st_exec_addr | input | ADDR_W | Address of the executing store |
| ld_retire | input | 1 | Retire the load at the queue head |
| st_retire | input | 1 | Retire the store at the queue head |
| squash_valid | output | 1 | One-cycle ordering violation pulse |
| squash_slot | output | IDX_W | Load queue slot of the violating load |
| squash_pc | output | PC_W | Instruction address of the violating load |
| hold_slot | input | IDX_W | Load slot whose wait status is queried |
| hold_wait | output | 1 | Queried load must wait for older stores |

## Verification
Two events can collide in one cycle. A store can resolve its address in the same cycle as a younger load to the same block executes. A squashing store execute can also arrive together with a new allocation. The bench drives both pairs in a single clock. It requires a squash naming the load in the first case. In the second it requires that the allocation leaves no trace, which shows in the next allocation receiving the squashed load's slot.

// File: rtl/lsod_pkg.sv
package lsod_pkg;

  localparam int BLK_LSB = 3;
  localparam int PC_LSB  = 2;

  // a is older than b on a wrapping counter of width w
  function automatic logic seq_before(input logic [31:0] a, input logic [31:0] b, input int w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction

  function automatic logic same_block(input logic [63:0] a, input logic [63:0] b);
    return (a >> BLK_LSB) == (b >> BLK_LSB);
  endfunction

  function automatic int unsigned mark_index(input logic [63:0] pc, input int w);
    logic [63:0] m;
    m = (pc >> PC_LSB) & ((64'd1 << w) - 64'd1);
    return int'(m[31:0]);
  endfunction

endpackage

// File: rtl/lsod_load_q.sv
module lsod_load_q
  import lsod_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int SEQ_W  = 7,
  parameter int ADDR_W = 48,
  parameter int PC_W   = 48,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic [PC_W-1:0]   alloc_pc,
  input  logic              alloc_wait,
  output logic [IDX_W-1:0]  tail_idx,
  output logic              full,
  output logic [CNT_W-1:0]  count,
  input  logic              exec_en,
  input  logic [IDX_W-1:0]  exec_idx,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic              retire_en,
  input  logic              probe_en,
  input  logic [SEQ_W-1:0]  probe_seq,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [SEQ_W-1:0]  hit_seq,
  output logic [PC_W-1:0]   hit_pc,
  input  logic [IDX_W-1:0]  query_idx,
  output logic              query_live,
  output logic              query_wait,
  output logic [SEQ_W-1:0]  query_seq
);

  logic [SEQ_W-1:0]  seq_q  [DEPTH];
  logic [PC_W-1:0]   pc_q   [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DEPTH-1:0]  done_q, wait_q, live, cand;
  logic [IDX_W-1:0]  head, tail;
  logic [CNT_W-1:0]  cnt;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [IDX_W-1:0]  ofs;
    logic              now_exec;
    logic [ADDR_W-1:0] use_addr;
    assign ofs      = IDX_W'(g) - head;
    assign live[g]  = {1'b0, ofs} < cnt;
    assign now_exec = exec_en && (exec_idx == IDX_W'(g));
    assign use_addr = now_exec ? exec_addr : addr_q[g];
    assign cand[g]  = probe_en && live[g] && (done_q[g] || now_exec) &&
                      seq_before(32'(probe_seq), 32'(seq_q[g]), SEQ_W) &&
                      same_block(64'(probe_addr), 64'(use_addr));
  end

  // oldest candidate = smallest distance from the head
  always_comb begin
    hit     = 1'b0;
    hit_idx = head;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (cand[head + IDX_W'(k)]) begin
        hit     = 1'b1;
        hit_idx = head + IDX_W'(k);
      end
    end
  end

  assign hit_seq    = seq_q[hit_idx];
  assign hit_pc     = pc_q[hit_idx];
  assign query_live = live[query_idx];
  assign query_wait = wait_q[query_idx];
  assign query_seq  = seq_q[query_idx];
  assign tail_idx   = tail;
  assign count      = cnt;
  assign full       = cnt == CNT_W'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head   <= '0;
      tail   <= '0;
      cnt    <= '0;
      done_q <= '0;
      wait_q <= '0;
    end else begin
      if (hit) begin
        tail <= hit_idx;
        cnt  <= {1'b0, IDX_W'(hit_idx - head)} - CNT_W'(retire_en);
      end else begin
        if (alloc_en) tail <= tail + IDX_W'(1);
        cnt <= cnt + CNT_W'(alloc_en) - CNT_W'(retire_en);
      end
      if (retire_en) head <= head + IDX_W'(1);
      if (alloc_en) begin
        done_q[tail] <= 1'b0;
        wait_q[tail] <= alloc_wait;
      end
      if (exec_en && live[exec_idx]) done_q[exec_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      seq_q[tail] <= alloc_seq;
      pc_q[tail]  <= alloc_pc;
    end
    if (exec_en && live[exec_idx]) addr_q[exec_idx] <= exec_addr;
  end

endmodule

// File: rtl/lsod_store_q.sv
module lsod_store_q
  import lsod_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int SEQ_W  = 7,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [SEQ_W-1:0] alloc_seq,
  output logic [IDX_W-1:0] tail_idx,
  output logic             full,
  output logic [CNT_W-1:0] count,
  input  logic             exec_en,
  input  logic [IDX_W-1:0] exec_idx,
  output logic             exec_live,
  output logic [SEQ_W-1:0] exec_seq,
  input  logic             retire_en,
  input  logic             trunc_en,
  input  logic [SEQ_W-1:0] trunc_seq,
  input  logic [SEQ_W-1:0] query_seq,
  output logic             older_pending
);

  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [DEPTH-1:0] done_q, live, keep, pend;
  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] cnt, keep_n;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [IDX_W-1:0] ofs;
    assign ofs     = IDX_W'(g) - head;
    assign live[g] = {1'b0, ofs} < cnt;
    assign keep[g] = live[g] && seq_before(32'(seq_q[g]), 32'(trunc_seq), SEQ_W);
    assign pend[g] = live[g] && !done_q[g] && seq_before(32'(seq_q[g]), 32'(query_seq), SEQ_W);
  end

  assign keep_n        = CNT_W'($countones(keep));
  assign older_pending = |pend;
  assign exec_live     = live[exec_idx];
  assign exec_seq      = seq_q[exec_idx];
  assign tail_idx      = tail;
  assign count         = cnt;
  assign full          = cnt == CNT_W'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head   <= '0;
      tail   <= '0;
      cnt    <= '0;
      done_q <= '0;
    end else begin
      if (trunc_en) begin
        tail <= head + keep_n[IDX_W-1:0];
        cnt  <= keep_n - CNT_W'(retire_en);
      end else begin
        if (alloc_en) tail <= tail + IDX_W'(1);
        cnt <= cnt + CNT_W'(alloc_en) - CNT_W'(retire_en);
      end
      if (retire_en) head <= head + IDX_W'(1);
      if (alloc_en) done_q[tail] <= 1'b0;
      if (exec_en && live[exec_idx]) done_q[exec_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) seq_q[tail] <= alloc_seq;
  end

endmodule

// File: rtl/lsod_wait_table.sv
module lsod_wait_table
  import lsod_pkg::*;
#(
  parameter int ENTRIES      = 64,
  parameter int PC_W         = 48,
  parameter int CLEAR_PERIOD = 16384,
  localparam int TBL_W = $clog2(ENTRIES),
  localparam int CLR_W = $clog2(CLEAR_PERIOD)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [PC_W-1:0] set_pc,
  input  logic [PC_W-1:0] look_pc,
  output logic            look_bit
);

  logic [ENTRIES-1:0] mark;
  logic [CLR_W-1:0]   tick;
  logic               wrap;
  logic [TBL_W-1:0]   set_ix, look_ix;

  assign wrap     = tick == CLR_W'(CLEAR_PERIOD - 1);
  assign set_ix   = TBL_W'(mark_index(64'(set_pc), TBL_W));
  assign look_ix  = TBL_W'(mark_index(64'(look_pc), TBL_W));
  assign look_bit = mark[look_ix];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark <= '0;
      tick <= '0;
    end else begin
      tick <= wrap ? '0 : tick + CLR_W'(1);
      if (wrap) mark <= '0;
      if (set_en) mark[set_ix] <= 1'b1;   // training wins over the periodic wipe
    end
  end

endmodule

// File: rtl/ld_st_order_check.sv
module ld_st_order_check
  import lsod_pkg::*;
#(
  parameter int QDEPTH       = 32,
  parameter int ADDR_W       = 48,
  parameter int PC_W         = 48,
  parameter int WAIT_ENTRIES = 64,
  parameter int CLEAR_PERIOD = 16384,
  localparam int IDX_W = $clog2(QDEPTH),
  localparam int CNT_W = IDX_W + 1,
  localparam int SEQ_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_is_store,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic [IDX_W-1:0]  alloc_slot,
  output logic              lq_full,
  output logic              sq_full,
  input  logic              ld_exec_valid,
  input  logic [IDX_W-1:0]  ld_exec_slot,
  input  logic [ADDR_W-1:0] ld_exec_addr,
  input  logic              st_exec_valid,
  input  logic [IDX_W-1:0]  st_exec_slot,
  input  logic [ADDR_W-1:0] st_exec_addr,
  input  logic              ld_retire,
  input  logic              st_retire,
  output logic              squash_valid,
  output logic [IDX_W-1:0]  squash_slot,
  output logic [PC_W-1:0]   squash_pc,
  input  logic [IDX_W-1:0]  hold_slot,
  output logic              hold_wait
);

  logic [SEQ_W-1:0] next_seq, hit_seq, st_seq, q_seq;
  logic [IDX_W-1:0] lq_tail, sq_tail, hit_idx;
  logic [CNT_W-1:0] lq_cnt, sq_cnt;
  logic [PC_W-1:0]  hit_pc;
  logic st_live, probe_en, viol_hit, ld_fire, st_fire;
  logic wait_bit, q_live, q_wait, older_pend;

  assign probe_en   = st_exec_valid && st_live;
  assign ld_fire    = alloc_valid && !alloc_is_store && !lq_full && !viol_hit;
  assign st_fire    = alloc_valid && alloc_is_store && !sq_full && !viol_hit;
  assign alloc_slot = alloc_is_store ? sq_tail : lq_tail;
  assign hold_wait  = q_live && q_wait && older_pend;

  lsod_load_q #(.DEPTH(QDEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .PC_W(PC_W)) u_lq (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(ld_fire), .alloc_seq(next_seq), .alloc_pc(alloc_pc), .alloc_wait(wait_bit),
    .tail_idx(lq_tail), .full(lq_full), .count(lq_cnt),
    .exec_en(ld_exec_valid), .exec_idx(ld_exec_slot), .exec_addr(ld_exec_addr),
    .retire_en(ld_retire),
    .probe_en(probe_en), .probe_seq(st_seq), .probe_addr(st_exec_addr),
    .hit(viol_hit), .hit_idx(hit_idx), .hit_seq(hit_seq), .hit_pc(hit_pc),
    .query_idx(hold_slot), .query_live(q_live), .query_wait(q_wait), .query_seq(q_seq)
  );

  lsod_store_q #(.DEPTH(QDEPTH), .SEQ_W(SEQ_W)) u_sq (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(st_fire), .alloc_seq(next_seq),
    .tail_idx(sq_tail), .full(sq_full), .count(sq_cnt),
    .exec_en(st_exec_valid), .exec_idx(st_exec_slot),
    .exec_live(st_live), .exec_seq(st_seq),
    .retire_en(st_retire),
    .trunc_en(viol_hit), .trunc_seq(hit_seq),
    .query_seq(q_seq), .older_pending(older_pend)
  );

  lsod_wait_table #(.ENTRIES(WAIT_ENTRIES), .PC_W(PC_W), .CLEAR_PERIOD(CLEAR_PERIOD)) u_wt (
    .clk(clk), .rst_n(rst_n),
    .set_en(viol_hit), .set_pc(hit_pc),
    .look_pc(alloc_pc), .look_bit(wait_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_seq     <= '0;
      squash_valid <= 1'b0;
      squash_slot  <= '0;
      squash_pc    <= '0;
    end else begin
      if (viol_hit) next_seq <= hit_seq;
      else if (ld_fire || st_fire) next_seq <= next_seq + SEQ_W'(1);
      squash_valid <= viol_hit;
      if (viol_hit) begin
        squash_slot <= hit_idx;
        squash_pc   <= hit_pc;
      end
    end
  end

endmodule

// File: rtl/ld_st_order_check_sva.sv
module ld_st_order_check_sva (
  input logic clk,
  input logic rst_n,
  input logic st_exec_valid,
  input logic squash_valid,
  input logic viol_hit,
  input logic lq_full,
  input logic ld_retire,
  input logic hold_wait,
  input logic lq_busy,
  input logic sq_busy
);

  // R3
  squash_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> $past(st_exec_valid));

  // R3
  squash_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_hit |-> lq_busy);

  // R7
  squash_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_hit |=> !lq_full);

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_full && !ld_retire && !viol_hit) |=> lq_full);

  // R9
  hold_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wait |-> sq_busy);

endmodule

bind ld_st_order_check ld_st_order_check_sva u_sva (
  .clk(clk), .rst_n(rst_n), .st_exec_valid(st_exec_valid),
  .squash_valid(squash_valid), .viol_hit(viol_hit), .lq_full(lq_full),
  .ld_retire(ld_retire), .hold_wait(hold_wait),
  .lq_busy(lq_cnt != '0), .sq_busy(sq_cnt != '0)
);

// File: tb/ld_st_order_check_test.sv
module ld_st_order_check_test;
  localparam int CP = 512;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        alloc_valid, alloc_is_store;
  logic [47:0] alloc_pc;
  logic [4:0]  alloc_slot;
  logic        lq_full, sq_full;
  logic        ld_exec_valid, st_exec_valid;
  logic [4:0]  ld_exec_slot, st_exec_slot;
  logic [47:0] ld_exec_addr, st_exec_addr;
  logic        ld_retire, st_retire;
  logic        squash_valid;
  logic [4:0]  squash_slot;
  logic [47:0] squash_pc;
  logic [4:0]  hold_slot;
  logic        hold_wait;

  ld_st_order_check #(.CLEAR_PERIOD(CP)) uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store), .alloc_pc(alloc_pc),
    .alloc_slot(alloc_slot), .lq_full(lq_full), .sq_full(sq_full),
    .ld_exec_valid(ld_exec_valid), .ld_exec_slot(ld_exec_slot), .ld_exec_addr(ld_exec_addr),
    .st_exec_valid(st_exec_valid), .st_exec_slot(st_exec_slot), .st_exec_addr(st_exec_addr),
    .ld_retire(ld_retire), .st_retire(st_retire),
    .squash_valid(squash_valid), .squash_slot(squash_slot), .squash_pc(squash_pc),
    .hold_slot(hold_slot), .hold_wait(hold_wait)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  localparam logic [47:0] PC_A = 48'h1004;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    alloc_valid = 0; alloc_is_store = 0; alloc_pc = '0;
    ld_exec_valid = 0; ld_exec_slot = '0; ld_exec_addr = '0;
    st_exec_valid = 0; st_exec_slot = '0; st_exec_addr = '0;
    ld_retire = 0; st_retire = 0; hold_slot = '0;
  endtask

  task automatic pulse();
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic alloc(input bit st, input logic [47:0] pc, output logic [4:0] slot);
    alloc_valid = 1; alloc_is_store = st; alloc_pc = pc;
    #1 slot = alloc_slot;
    pulse();
  endtask

  task automatic lexec(input logic [4:0] slot, input logic [47:0] addr);
    ld_exec_valid = 1; ld_exec_slot = slot; ld_exec_addr = addr;
    pulse();
  endtask

  task automatic sexec(input logic [4:0] slot, input logic [47:0] addr);
    st_exec_valid = 1; st_exec_slot = slot; st_exec_addr = addr;
    pulse();
  endtask

  task automatic hold_of(input logic [4:0] slot, output logic h);
    hold_slot = slot;
    #1 h = hold_wait;
  endtask

  task automatic drain(input int nl, input int ns);
    for (int i = 0; i < nl; i++) begin ld_retire = 1; pulse(); end
    for (int i = 0; i < ns; i++) begin st_retire = 1; pulse(); end
  endtask

  task automatic t_reset();
    check("R1 squash_valid", squash_valid, 0);
    check("R1 lq_full", lq_full, 0);
    check("R1 sq_full", sq_full, 0);
    check("R1 hold_wait", hold_wait, 0);
    check("R1 alloc_slot", alloc_slot, 0);
  endtask

  task automatic t_basic();
    logic [4:0] s0, l0;
    alloc(1, 48'h2000, s0);
    alloc(0, PC_A, l0);
    lexec(l0, 48'h100);
    sexec(s0, 48'h104);
    check("R3 squash_valid", squash_valid, 1);
    check("R3 squash_slot", squash_slot, l0);
    check("R3 squash_pc", squash_pc, PC_A);
    pulse();
    check("R3 squash one cycle", squash_valid, 0);
    drain(0, 1);
  endtask

  task automatic t_no_match();
    logic [4:0] la, sb, lc, ld, se, lf;
    alloc(0, 48'h3000, la);
    alloc(1, 48'h3004, sb);
    alloc(0, 48'h3008, lc);
    alloc(0, 48'h300c, ld);
    alloc(1, 48'h3010, se);
    alloc(0, 48'h3014, lf);
    lexec(la, 48'h200);
    lexec(ld, 48'h208);
    sexec(sb, 48'h200);
    check("R4 older/unexecuted/other-block loads no squash", squash_valid, 0);
    lexec(lf, 48'h307);
    sexec(se, 48'h300);
    check("R5 low bits ignored squash", squash_valid, 1);
    check("R5 squash_slot", squash_slot, lf);
    drain(3, 2);
  endtask

  task automatic t_oldest();
    logic [4:0] s1, l1, s2, l2, ln, sn;
    alloc(1, 48'h1018, s1);
    alloc(0, 48'h1020, l1);
    alloc(1, 48'h1024, s2);
    alloc(0, 48'h1028, l2);
    lexec(l2, 48'h400);
    lexec(l1, 48'h404);
    alloc_valid = 1; alloc_is_store = 0; alloc_pc = 48'h7777;
    sexec(s1, 48'h400);
    check("R6 oldest slot", squash_slot, l1);
    check("R6 oldest pc", squash_pc, 48'h1020);
    alloc(0, 48'h2040, ln);
    check("R13 ignored alloc leaves slot", ln, l1);
    alloc(1, 48'h2044, sn);
    check("R7 store slot reused", sn, s2);
    drain(1, 2);
  endtask

  task automatic t_same_cycle();
    logic [4:0] s, l;
    alloc(1, 48'h102c, s);
    alloc(0, 48'h1030, l);
    ld_exec_valid = 1; ld_exec_slot = l; ld_exec_addr = 48'h500;
    sexec(s, 48'h503);
    check("R8 same-cycle squash", squash_valid, 1);
    check("R8 same-cycle slot", squash_slot, l);
    drain(0, 1);
  endtask

  task automatic t_train();
    logic [4:0] lp0, sx, lp1, lp2, lp3;
    logic h;
    alloc(0, PC_A, lp0);
    hold_of(lp0, h);
    check("R10 no older store", h, 0);
    alloc(1, 48'h6000, sx);
    alloc(0, PC_A, lp1);
    alloc(0, 48'h1104, lp2);
    alloc(0, 48'h1040, lp3);
    hold_of(lp1, h);
    check("R9 trained load holds", h, 1);
    hold_of(lp2, h);
    check("R9 aliasing pc holds", h, 1);
    hold_of(lp3, h);
    check("R10 untrained load free", h, 0);
    idle_inputs();
    sexec(sx, 48'h900);
    check("R9 unrelated store no squash", squash_valid, 0);
    hold_of(lp1, h);
    check("R9 released after store exec", h, 0);
    idle_inputs();
    drain(4, 1);
  endtask

  task automatic t_clear();
    logic [4:0] s, l;
    logic h;
    repeat (2 * CP + 50) @(negedge clk);
    alloc(1, 48'h6100, s);
    alloc(0, PC_A, l);
    hold_of(l, h);
    check("R11 marks wiped", h, 0);
    idle_inputs();
    drain(1, 1);
  endtask

  task automatic t_fill();
    logic [4:0] first, sl;
    alloc(0, 48'h8000, first);
    for (int i = 1; i < 32; i++) alloc(0, 48'h8000 + 48'(4 * i), sl);
    check("R2 lq_full at 32", lq_full, 1);
    alloc(0, 48'h8100, sl);
    ld_retire = 1; pulse();
    check("R2 full alloc ignored", lq_full, 0);
    alloc(0, 48'h8200, sl);
    check("R12 slot wraps to freed head", sl, first);
    check("R12 full again", lq_full, 1);
    drain(32, 0);
    check("R12 empty after retire", lq_full, 0);
    for (int i = 0; i < 32; i++) alloc(1, 48'h9000, sl);
    check("R2 sq_full at 32", sq_full, 1);
    drain(0, 32);
    check("R2 sq drained", sq_full, 0);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    @(negedge clk);
    t_basic();
    t_no_match();
    t_oldest();
    t_same_cycle();
    t_train();
    t_clear();
    t_fill();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule